// File: doc/BRIEF.md
# Multi-Channel PWM with One-Shot Global Commit

The block drives a set of PWM channels from a single up-counting time base. Every channel owns two compare values; the counter period is shared by all channels. Each of these values is written by the host into a shadow register at any moment. The shadow contents become active only through one shared, write-only arm bit. Once armed, the next counter-zero event copies the period and every channel's compare pair from shadow to active in the same clock, and the arm then clears itself.

Each channel turns its active compare pair into a single waveform, then a dead-band stage splits it into a delayed true output and a delayed complement. A simple register port gives write access to the shadows, the arm bit, the run and sync controls and the per-channel configuration. Reads return the active values as well, so software can see which values are live. The block does not hide late writes. If a channel's shadow is written after the zero event has already consumed the arm, that channel keeps its old active values until the next armed zero, while the other channels have already moved on.

Top module: `pwm_glb_load`

## Requirements
- R1: While the run bit (control address 0, bit 0) is 1, the counter steps 0,1,..,P,0 with P the active period, so `zero_o` pulses for one cycle every P+1 cycles. While run is 0 the counter holds its value and `zero_o` stays low.
- R2: Shadow registers are written at any time and read back at their own addresses. Reads take one cycle: `rd_data` is valid with `rd_valid` in the cycle after `rd_en`. The map is: period shadow at 1, active period at 2 (read-only), and channel n at 8+8n. Within a channel, +0 is the compare A shadow and +1 the compare B shadow. +4 and +5 read the active A and B values.
- R3: Writing 1 to the arm bit (address 0, bit 1) arms a commit. At the next cycle with the counter at zero and run set, the period shadow and all channels' compare shadows are copied to active together, and the arm clears. Without the arm, active values never change at a zero event.
- R4: Writing 0 to the arm bit does not disarm; only a completed commit clears it.
- R5: The arm bit always reads as 0, even while armed.
- R6: A shadow write made after the zero event that consumed the arm stays out of the active register until a later armed zero. That channel therefore keeps its previous active values while the other channels already use new ones.
- R7: If a shadow write lands in the same clock as a commit, the shadow takes the new value and the active register takes the shadow value from before that write.
- R8: With a channel enabled, its waveform goes high in the cycle after the counter equals active compare B. It goes low in the cycle after the counter equals active compare A, so the on-time is A−B cycles for B<A.
- R9: Channel config bit 1 turns on the dead band. Offset +3 holds the rising delay in bits 7:0 and the falling delay in bits 15:8. Output A rises a rising-delay after the waveform rises and falls with it. Output B rises a falling-delay after the waveform falls and falls when the waveform rises. A and B are never high together. An on-time not longer than the rising delay gives no pulse on A.
- R10: While a channel's enable (config offset +2, bit 0) is 0, both of its outputs are low.
- R11: Writing 1 to the sync bit (address 0, bit 2) forces the counter to 0 in the next cycle. In the same clock, channels whose config bit 2 is set copy their compare shadows to active without needing the arm. Other channels keep their active values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | AW | Register read address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 16 | Read data |
| ctr_o | output | 16 | Current time-base count |
| zero_o | output | 1 | One-cycle counter-zero strobe |
| pwm_a | output | NCH | Per-channel true output after dead band |
| pwm_b | output | NCH | Per-channel complementary output after dead band |

## Verification
The bench drives a shadow write in exactly the clock of an armed zero event. A design that lets the new value pass straight to active, or that drops the write, shows the wrong active or shadow value. It writes one channel after the commit has consumed the arm and confirms the stale pairing persists. A design that holds the arm open too long, or clears it on a zero write, commits that channel early. Pulse widths are counted over whole periods with and without dead band, including an on-time shorter than the rising delay. A wrong delay or a missing suppression changes those counts. A sync with the load-on-sync option on one channel and off on another shows whether the option is applied per channel.

// File: rtl/pwm_glb_pkg.sv
package pwm_glb_pkg;

    localparam int CW  = 16;
    localparam int DBW = 8;

    localparam int G_CTRL    = 0;
    localparam int G_PRD     = 1;
    localparam int G_PRD_ACT = 2;
    localparam int CH_BASE   = 8;
    localparam int CH_STRIDE = 8;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_ARM  = 1;
    localparam int CTRL_SYNC = 2;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [2:0] {
        F_SHA  = 3'd0,
        F_SHB  = 3'd1,
        F_CFG  = 3'd2,
        F_DB   = 3'd3,
        F_ACTA = 3'd4,
        F_ACTB = 3'd5
    } ch_field_e;

    typedef struct packed {
        logic sync_ld;
        logic db_en;
        logic en;
    } ch_cfg_t;

    typedef struct packed {
        logic [DBW-1:0] fed;
        logic [DBW-1:0] red;
    } db_cfg_t;

    typedef struct packed {
        cnt_t a;
        cnt_t b;
    } cmp_pair_t;

    function automatic logic [DBW-1:0] sat_inc(input logic [DBW-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_glb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sync,
    input  cnt_t prd,
    output cnt_t ctr,
    output logic zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr <= '0;
        end else if (sync) begin
            ctr <= '0;
        end else if (run) begin
            ctr <= (ctr >= prd) ? '0 : ctr + 1'b1;
        end
    end

    assign zero = run && (ctr == '0);

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        (run && !sync && ctr < prd) |=> ctr == $past(ctr) + 1'b1);

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!run && !sync) |=> $stable(ctr));

    assert_sync_R11: assert property (@(posedge clk) disable iff (rst)
        sync |=> ctr == '0);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_glb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [2:0] field,
    input  cnt_t      wdata,
    input  logic      gld,
    input  logic      sync,
    input  cnt_t      ctr,
    output logic      aq,
    output ch_cfg_t   cfg,
    output db_cfg_t   db,
    output cmp_pair_t sh,
    output cmp_pair_t act
);

    logic commit;
    assign commit = gld || (sync && cfg.sync_ld);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            act <= '0;
            cfg <= '0;
            db  <= '0;
        end else begin
            if (wr && field == F_SHA) sh.a <= wdata;
            if (wr && field == F_SHB) sh.b <= wdata;
            if (wr && field == F_CFG) cfg  <= ch_cfg_t'(wdata[2:0]);
            if (wr && field == F_DB)  db   <= db_cfg_t'(wdata);
            if (commit)               act  <= sh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg.en) begin
            aq <= 1'b0;
        end else if (ctr == act.a) begin
            aq <= 1'b0;
        end else if (ctr == act.b) begin
            aq <= 1'b1;
        end
    end

    assert_act_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(act));

    assert_set_on_b_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && ctr == act.b && ctr != act.a && !(wr && field == F_CFG)) |=> aq);

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
    import pwm_glb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    db_en,
    input  logic    aq,
    input  db_cfg_t db,
    output logic    pa,
    output logic    pb
);

    logic [DBW-1:0] hi_cnt;
    logic [DBW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= aq ? sat_inc(hi_cnt) : '0;
            lo_cnt <= aq ? '0 : sat_inc(lo_cnt);
        end
    end

    always_comb begin
        if (!en) begin
            pa = 1'b0;
            pb = 1'b0;
        end else if (!db_en) begin
            pa = aq;
            pb = !aq;
        end else begin
            pa = aq && (hi_cnt >= db.red);
            pb = !aq && (lo_cnt >= db.fed);
        end
    end

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        !(pa && pb));

    assert_rise_delay_R9: assert property (@(posedge clk) disable iff (rst)
        (en && db_en && db.red != '0 && $rose(aq)) |-> !pa);

    assert_off_low_R10: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!pa && !pb));

endmodule

// File: rtl/pwm_glb_load.sv
module pwm_glb_load
    import pwm_glb_pkg::*;
#(
    parameter  int NCH = 4,
    localparam int AW  = $clog2(CH_BASE + NCH * CH_STRIDE)
)
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic           rd_en,
    input  logic [AW-1:0]  rd_addr,
    output logic           rd_valid,
    output logic [CW-1:0]  rd_data,
    output logic [CW-1:0]  ctr_o,
    output logic           zero_o,
    output logic [NCH-1:0] pwm_a,
    output logic [NCH-1:0] pwm_b
);

    localparam int FW = $clog2(CH_STRIDE);
    localparam int IW = AW - FW;

    logic run_q;
    logic arm_q;
    logic ctrl_wr;
    logic arm_wr;
    logic sync_p;
    logic gld;
    cnt_t prd_sh_q;
    cnt_t prd_act_q;
    cnt_t ctr;
    logic zero;

    assign ctrl_wr = wr_en && (wr_addr == AW'(G_CTRL));
    assign arm_wr  = ctrl_wr && wr_data[CTRL_ARM];
    assign sync_p  = ctrl_wr && wr_data[CTRL_SYNC];
    assign gld     = zero && arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            arm_q     <= 1'b0;
            prd_sh_q  <= '0;
            prd_act_q <= '0;
        end else begin
            if (ctrl_wr) run_q <= wr_data[CTRL_RUN];
            arm_q <= (arm_q && !gld) || arm_wr;
            if (wr_en && wr_addr == AW'(G_PRD)) prd_sh_q <= wr_data;
            if (gld) prd_act_q <= prd_sh_q;
        end
    end

    pwm_timebase u_tb (
        .clk  (clk),
        .rst  (rst),
        .run  (run_q),
        .sync (sync_p),
        .prd  (prd_act_q),
        .ctr  (ctr),
        .zero (zero)
    );

    assign ctr_o  = ctr;
    assign zero_o = zero;

    ch_cfg_t   cfg_v [NCH];
    db_cfg_t   db_v  [NCH];
    cmp_pair_t sh_v  [NCH];
    cmp_pair_t act_v [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        logic aq;
        assign hit = wr_en && (wr_addr[AW-1:FW] == IW'(CH_BASE / CH_STRIDE + i));

        pwm_chan u_ch (
            .clk   (clk),
            .rst   (rst),
            .wr    (hit),
            .field (wr_addr[FW-1:0]),
            .wdata (wr_data),
            .gld   (gld),
            .sync  (sync_p),
            .ctr   (ctr),
            .aq    (aq),
            .cfg   (cfg_v[i]),
            .db    (db_v[i]),
            .sh    (sh_v[i]),
            .act   (act_v[i])
        );

        pwm_deadband u_db (
            .clk   (clk),
            .rst   (rst),
            .en    (cfg_v[i].en),
            .db_en (cfg_v[i].db_en),
            .aq    (aq),
            .db    (db_v[i]),
            .pa    (pwm_a[i]),
            .pb    (pwm_b[i])
        );
    end

    logic [CW-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (rd_addr == AW'(G_CTRL)) begin
            rd_mux = CW'(run_q);
        end else if (rd_addr == AW'(G_PRD)) begin
            rd_mux = prd_sh_q;
        end else if (rd_addr == AW'(G_PRD_ACT)) begin
            rd_mux = prd_act_q;
        end
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr[AW-1:FW] == IW'(CH_BASE / CH_STRIDE + i)) begin
                case (rd_addr[FW-1:0])
                    F_SHA:   rd_mux = sh_v[i].a;
                    F_SHB:   rd_mux = sh_v[i].b;
                    F_CFG:   rd_mux = CW'(cfg_v[i]);
                    F_DB:    rd_mux = db_v[i];
                    F_ACTA:  rd_mux = act_v[i].a;
                    F_ACTB:  rd_mux = act_v[i].b;
                    default: rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    assert_arm_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (gld && !arm_wr) |=> !arm_q);

    assert_arm_sticks_R4: assert property (@(posedge clk) disable iff (rst)
        (arm_q && !gld) |=> arm_q);

    assert_arm_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == AW'(G_CTRL)) |=> !rd_data[CTRL_ARM]);

    assert_prd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !gld |=> $stable(prd_act_q));

endmodule

// File: tb/pwm_glb_load_test.sv
module pwm_glb_load_test;
    import pwm_glb_pkg::*;

    localparam int NCH = 4;
    localparam int AW  = $clog2(CH_BASE + NCH * CH_STRIDE);
    localparam int PRD = 99;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  rd_addr = '0;
    logic           rd_valid;
    logic [CW-1:0]  rd_data;
    logic [CW-1:0]  ctr_o;
    logic           zero_o;
    logic [NCH-1:0] pwm_a;
    logic [NCH-1:0] pwm_b;

    pwm_glb_load #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .ctr_o(ctr_o), .zero_o(zero_o), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    addr;
        int    exp;
        string req;
    } rd_item_t;

    rd_item_t sb_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    function automatic int ca(int ch, int f);
        return CH_BASE + CH_STRIDE * ch + f;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected read item, then issues the read
    task automatic rd(int a, int exp, string req);
        rd_item_t it;
        it.addr = a; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_zero();
        while (zero_o !== 1'b1) @(negedge clk);
    endtask

    task automatic measure(int ch, int n, output int ha, output int hb, output int ov);
        ha = 0; hb = 0; ov = 0;
        for (int k = 0; k < n; k++) begin
            if (pwm_a[ch]) ha++;
            if (pwm_b[ch]) hb++;
            if (pwm_a[ch] && pwm_b[ch]) ov++;
            @(negedge clk);
        end
    endtask

    // monitor: pops and compares as read data appears
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb_q.size() == 0) begin
                check("R2", 1, 0, "read data with no expected item");
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.req, int'(rd_data), it.exp, $sformatf("read at address %0d", it.addr));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int ha, hb, ov, span, held;
        tick(5);
        rst = 1'b0;
        tick(1);

        // reset state
        check("R1", int'(ctr_o), 0, "counter after reset");
        check("R1", int'(zero_o), 0, "zero strobe while stopped");
        check("R10", int'(pwm_a | pwm_b), 0, "outputs after reset");
        rd(G_CTRL, 0, "R5");

        // configure shadows
        wr(G_PRD, PRD);
        wr(ca(0, 0), 50); wr(ca(0, 1), 10); wr(ca(0, 2), 1);
        wr(ca(1, 0), 30); wr(ca(1, 1), 20); wr(ca(1, 2), 3); wr(ca(1, 3), 16'h0503);
        wr(ca(2, 0), 60); wr(ca(2, 1), 40); wr(ca(2, 2), 5);
        wr(ca(3, 0), 70); wr(ca(3, 1), 65); wr(ca(3, 2), 3); wr(ca(3, 3), 16'h0208);
        rd(ca(0, 0), 50, "R2");
        rd(ca(1, 3), 16'h0503, "R2");
        rd(ca(0, 4), 0, "R2");
        rd(G_PRD_ACT, 0, "R3");

        // run and arm: commit at the next zero
        wr(G_CTRL, 3);
        rd(G_CTRL, 1, "R5");
        rd(G_PRD_ACT, PRD, "R3");
        rd(ca(1, 4), 30, "R3");
        rd(ca(3, 5), 65, "R3");

        // period spacing
        wait_zero(); tick(1);
        span = 1;
        while (zero_o !== 1'b1) begin span++; tick(1); end
        check("R1", span, PRD + 1, "cycles between zero strobes");

        // waveforms over whole periods
        tick(1); wait_zero();
        measure(0, PRD + 1, ha, hb, ov);
        check("R8", ha, 40, "ch0 A high cycles");
        check("R8", hb, 60, "ch0 B high cycles");
        wait_zero();
        measure(1, PRD + 1, ha, hb, ov);
        check("R9", ha, 7, "ch1 A high with rising delay");
        check("R9", hb, 85, "ch1 B high with falling delay");
        check("R9", ov, 0, "ch1 overlap cycles");
        wait_zero();
        measure(3, PRD + 1, ha, hb, ov);
        check("R9", ha, 0, "ch3 A with on-time under rising delay");
        check("R9", hb, 93, "ch3 B high cycles");

        // no commit without arm
        wr(ca(0, 0), 20);
        wait_zero(); tick(1); wait_zero(); tick(1);
        rd(ca(0, 4), 50, "R3");

        // writing 0 to arm does not disarm
        wr(G_CTRL, 3);
        wr(G_CTRL, 1);
        wait_zero(); tick(1);
        rd(ca(0, 4), 20, "R4");

        // late write after commit keeps stale value in that channel
        wr(ca(0, 0), 45);
        wr(G_CTRL, 3);
        wait_zero(); tick(1);
        wr(ca(1, 0), 35);
        rd(ca(0, 4), 45, "R6");
        rd(ca(1, 4), 30, "R6");
        wait_zero();
        measure(1, PRD + 1, ha, hb, ov);
        check("R6", ha, 7, "ch1 still uses stale compare A");
        wr(G_CTRL, 3);
        wait_zero(); tick(1);
        rd(ca(1, 4), 35, "R6");

        // shadow write in the commit clock
        wr(ca(0, 0), 25);
        wr(G_CTRL, 3);
        wait_zero();
        wr(ca(0, 0), 60);
        rd(ca(0, 4), 25, "R7");
        rd(ca(0, 0), 60, "R7");
        wr(G_CTRL, 3);
        wait_zero(); tick(1);
        rd(ca(0, 4), 60, "R7");

        // forced sync with per-channel load option
        wait_zero(); tick(30);
        wr(ca(2, 0), 55);
        wr(ca(3, 0), 75);
        wr(G_CTRL, 5);
        check("R11", int'(ctr_o), 0, "counter after forced sync");
        rd(ca(2, 4), 55, "R11");
        rd(ca(3, 4), 70, "R11");

        // disabled channel
        wr(ca(0, 2), 0);
        wait_zero();
        measure(0, PRD + 1, ha, hb, ov);
        check("R10", ha + hb, 0, "ch0 output cycles while disabled");

        // stop the counter
        wr(G_CTRL, 0);
        tick(3);
        held = int'(ctr_o);
        tick(5);
        check("R1", int'(ctr_o), held, "counter held while stopped");
        check("R1", int'(zero_o), 0, "zero strobe while stopped");

        tick(3);
        check("R2", sb_q.size(), 0, "pending read items");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule